// File: doc/BRIEF.md
# CSR State-Enable Access Checker

This block decides, for a single control/status register access, whether the access may go ahead or must end in an exception. It guards three registers: the floating-point control register, the supervisor environment configuration register and the hypervisor environment configuration register. An upstream stage has already run the ordinary existence and privilege test and hands over its result as a base fault. The checker then applies up to three state-enable gates, one for each of the machine, hypervisor and supervisor levels, in a fixed priority order. The first failing test selects the exception. Depending on the gate and on whether the hart is running virtualized, that is either an illegal-instruction trap or a virtual-instruction trap.

The inputs are the privilege level, the virtualization bit, three extension-present flags, the target register code and the low words of the three state-enable registers. Each access produces exactly one of three outputs: allow, illegal-instruction trap or virtual-instruction trap. With the default parameters the verdict is registered, so it appears one clock after the access is presented. The bit positions inside the state-enable words are parameters.

Top module: `seac_access_check`

## Requirements
- R1: When `acc_valid` is 0, all three outputs are 0. When `acc_valid` is 1, exactly one of `allow_o`, `trap_ill_o` or `trap_virt_o` is 1.
- R2: A base fault wins over every state-enable gate. `base_virt`=1 reports it as a virtual-instruction trap, and `base_virt`=0 reports it as an illegal-instruction trap.
- R3: With `ext_stateen`=0, only the base result counts, and an access without a base fault is allowed.
- R4: Target codes are 0 = floating-point control, 1 = supervisor environment config, 2 = hypervisor environment config and 3 = unguarded. Code 3 is never gated. Code 0 is gated only when `ext_fp_in_int`=1.
- R5: Machine gate: if privilege is not machine and the selected bit of `m_word` is 0, the result is an illegal-instruction trap. The selected bit is bit 1 for target 0 and bit 62 for targets 1 and 2. No other bit has any effect.
- R6: Hypervisor gate, for targets 0 and 1 only: if `virt_mode`=1, privilege is not machine and the selected bit of `h_word` is 0, the result is a virtual-instruction trap.
- R7: Supervisor gate, for target 0 only: if `ext_smode`=1, privilege is user (0) and bit 1 of `s_word` is 0, the result is a virtual-instruction trap when `virt_mode`=1 and an illegal-instruction trap otherwise. Privilege codes are 0 = user, 1 = supervisor and 3 = machine. The reserved code 2 counts as not-user and not-machine.
- R8: The gates are evaluated in the order base, machine, hypervisor, supervisor. The first failing gate decides the trap.
- R9: A machine-mode access (privilege 3) never raises a state-enable trap.
- R10: Target 2 passes only the machine gate and never receives a virtual-instruction trap from a state-enable gate.
- R11: The verdict is registered. It appears on the outputs one clock after the inputs, and all outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| virt_mode | input | 1 | Hart is running virtualized |
| ext_stateen | input | 1 | State-enable extension present |
| ext_fp_in_int | input | 1 | Floating point held in integer registers |
| ext_smode | input | 1 | Supervisor mode exists |
| tgt | input | 2 | Target register code |
| m_word | input | W | Machine state-enable low word |
| h_word | input | W | Hypervisor state-enable low word |
| s_word | input | W | Supervisor state-enable low word |
| base_fault | input | 1 | Upstream base permission failed |
| base_virt | input | 1 | Base fault is a virtual-instruction fault |
| allow_o | output | 1 | Access may proceed |
| trap_ill_o | output | 1 | Raise illegal-instruction trap |
| trap_virt_o | output | 1 | Raise virtual-instruction trap |

## Verification
The main function is swept over every combination of privilege, virtualization, the three extension flags, target code, gate-bit state and base fault. In this sweep the gate words are either all ones or have both enable bits cleared. Each result is compared with an independent priority model, which separates the gate order and the per-target gate sets. A table of vectors then clears only one of the two enable bits, or only one level's word. These vectors show that each target reads its own bit and that a failing lower gate is hidden by an earlier one. Directed tests cover the reset state, an idle cycle and the one-cycle latency.

// File: rtl/seac_pkg.sv
package seac_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TGT_FP_CTL  = 2'd0,
    TGT_SUP_ENV = 2'd1,
    TGT_HYP_ENV = 2'd2,
    TGT_OTHER   = 2'd3
  } tgt_e;

  // result of one gate: fail flag and trap kind (1 = virtual-instruction)
  typedef struct packed {
    logic fail;
    logic virt;
  } gate_res_t;

  localparam int unsigned NUM_GATES = 3;
  localparam int unsigned GATE_MACH = 0;
  localparam int unsigned GATE_HYP  = 1;
  localparam int unsigned GATE_SUP  = 2;

endpackage

// File: rtl/seac_gate.sv
module seac_gate
  import seac_pkg::*;
#(
  parameter int unsigned W       = 64,
  parameter int unsigned LEVEL   = GATE_MACH,
  parameter int unsigned FP_BIT  = 1,
  parameter int unsigned ENV_BIT = 62
) (
  input  logic      active,
  input  priv_e     priv,
  input  logic      virt_mode,
  input  logic      smode_present,
  input  tgt_e      tgt,
  input  logic [W-1:0] en_word,
  output gate_res_t res
);

  logic en_bit;
  logic below_mach;

  assign en_bit     = (tgt == TGT_FP_CTL) ? en_word[FP_BIT] : en_word[ENV_BIT];
  assign below_mach = (priv != PRIV_MACH);

  generate
    if (LEVEL == GATE_MACH) begin : g_mach
      always_comb begin
        res.fail = active && below_mach && !en_bit;
        res.virt = 1'b0;
      end
    end else if (LEVEL == GATE_HYP) begin : g_hyp
      always_comb begin
        res.fail = active && (tgt != TGT_HYP_ENV) && virt_mode &&
                   below_mach && !en_bit;
        res.virt = 1'b1;
      end
    end else begin : g_sup
      always_comb begin
        res.fail = active && (tgt == TGT_FP_CTL) && smode_present &&
                   (priv == PRIV_USER) && !en_word[FP_BIT];
        res.virt = virt_mode;
      end
    end
  endgenerate

endmodule

// File: rtl/seac_resolve.sv
module seac_resolve
  import seac_pkg::*;
#(
  parameter int unsigned N = NUM_GATES
) (
  input  logic                 acc_valid,
  input  logic                 base_fault,
  input  logic                 base_virt,
  input  gate_res_t [N-1:0]    gates,
  output logic                 allow,
  output logic                 trap_ill,
  output logic                 trap_virt
);

  logic hit;
  logic kind;

  // first failing stage in order base, gates[0], gates[1], ...
  always_comb begin
    hit  = base_fault;
    kind = base_virt;
    for (int i = 0; i < int'(N); i++) begin
      if (!hit && gates[i].fail) begin
        hit  = 1'b1;
        kind = gates[i].virt;
      end
    end
    allow     = acc_valid && !hit;
    trap_ill  = acc_valid && hit && !kind;
    trap_virt = acc_valid && hit && kind;
  end

endmodule

// File: rtl/seac_access_check.sv
module seac_access_check
  import seac_pkg::*;
#(
  parameter int unsigned W       = 64,
  parameter int unsigned FP_BIT  = 1,
  parameter int unsigned ENV_BIT = 62,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  input  logic [1:0]   priv,
  input  logic         virt_mode,
  input  logic         ext_stateen,
  input  logic         ext_fp_in_int,
  input  logic         ext_smode,
  input  logic [1:0]   tgt,
  input  logic [W-1:0] m_word,
  input  logic [W-1:0] h_word,
  input  logic [W-1:0] s_word,
  input  logic         base_fault,
  input  logic         base_virt,
  output logic         allow_o,
  output logic         trap_ill_o,
  output logic         trap_virt_o
);

  priv_e priv_q;
  tgt_e  tgt_q;
  logic  active;
  logic [NUM_GATES-1:0][W-1:0] word_bus;
  gate_res_t [NUM_GATES-1:0]   gate_res;
  logic  nxt_allow, nxt_ill, nxt_virt;

  assign priv_q = priv_e'(priv);
  assign tgt_q  = tgt_e'(tgt);

  // state-enable checks apply only with the extension, and for the
  // floating-point target only when it lives in integer registers
  assign active = ext_stateen &&
                  ((tgt_q == TGT_FP_CTL) ? ext_fp_in_int : (tgt_q != TGT_OTHER));

  assign word_bus[GATE_MACH] = m_word;
  assign word_bus[GATE_HYP]  = h_word;
  assign word_bus[GATE_SUP]  = s_word;

  generate
    for (genvar g = 0; g < int'(NUM_GATES); g++) begin : g_gate
      seac_gate #(
        .W       (W),
        .LEVEL   (g),
        .FP_BIT  (FP_BIT),
        .ENV_BIT (ENV_BIT)
      ) i_gate (
        .active        (active),
        .priv          (priv_q),
        .virt_mode     (virt_mode),
        .smode_present (ext_smode),
        .tgt           (tgt_q),
        .en_word       (word_bus[g]),
        .res           (gate_res[g])
      );
    end
  endgenerate

  seac_resolve #(.N(NUM_GATES)) i_resolve (
    .acc_valid  (acc_valid),
    .base_fault (base_fault),
    .base_virt  (base_virt),
    .gates      (gate_res),
    .allow      (nxt_allow),
    .trap_ill   (nxt_ill),
    .trap_virt  (nxt_virt)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic allow_q, ill_q, virt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          allow_q <= 1'b0;
          ill_q   <= 1'b0;
          virt_q  <= 1'b0;
        end else begin
          allow_q <= nxt_allow;
          ill_q   <= nxt_ill;
          virt_q  <= nxt_virt;
        end
      end
      assign allow_o     = allow_q;
      assign trap_ill_o  = ill_q;
      assign trap_virt_o = virt_q;
    end else begin : g_comb
      assign allow_o     = nxt_allow;
      assign trap_ill_o  = nxt_ill;
      assign trap_virt_o = nxt_virt;
    end
  endgenerate

  AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({allow_o, trap_ill_o, trap_virt_o})); // R1

  AST_VALID_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones({nxt_allow, nxt_ill, nxt_virt}) == 1)); // R1

  AST_BASE_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && base_fault) |-> (!nxt_allow && (nxt_virt == base_virt))); // R2

  AST_STATEEN_OFF_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ext_stateen && !base_fault) |-> nxt_allow); // R3

  AST_MACH_NEVER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (priv == 2'd3) && !base_fault) |-> nxt_allow); // R9

  AST_HYP_ENV_NO_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (tgt == 2'd2) && !base_fault) |-> !nxt_virt); // R10

  AST_UNGUARDED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (tgt == 2'd3) && !base_fault) |-> nxt_allow); // R4

endmodule

// File: tb/test_seac_access_check.sv
module test_seac_access_check;

  localparam int W = 64;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] NO1  = ~(64'd1 << 1);
  localparam logic [W-1:0] NO62 = ~(64'd1 << 62);
  localparam logic [W-1:0] NOBOTH = ~((64'd1 << 1) | (64'd1 << 62));

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, virt_mode, ext_stateen, ext_fp_in_int, ext_smode;
  logic [1:0] priv, tgt;
  logic [W-1:0] m_word, h_word, s_word;
  logic base_fault, base_virt;
  logic allow_o, trap_ill_o, trap_virt_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seac_access_check i_seac_access_check (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .priv(priv),
    .virt_mode(virt_mode), .ext_stateen(ext_stateen),
    .ext_fp_in_int(ext_fp_in_int), .ext_smode(ext_smode), .tgt(tgt),
    .m_word(m_word), .h_word(h_word), .s_word(s_word),
    .base_fault(base_fault), .base_virt(base_virt),
    .allow_o(allow_o), .trap_ill_o(trap_ill_o), .trap_virt_o(trap_virt_o)
  );

  // code: 0 allow, 1 illegal, 2 virtual, 3 nothing, 4 several
  function automatic int out_code();
    case ({allow_o, trap_ill_o, trap_virt_o})
      3'b100:  return 0;
      3'b010:  return 1;
      3'b001:  return 2;
      3'b000:  return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int ref_code(input logic v, input logic [1:0] p,
      input logic vm, input logic st, input logic fi, input logic sm,
      input logic [1:0] t, input logic [W-1:0] mw, input logic [W-1:0] hw,
      input logic [W-1:0] sw, input logic bf, input logic bv,
      output string tag);
    int pos;
    pos = (t == 2'd0) ? 1 : 62;
    if (!v) begin tag = "R1"; return 3; end
    if (bf) begin tag = "R2"; return bv ? 2 : 1; end
    if (!st) begin tag = "R3"; return 0; end
    if (t == 2'd3 || (t == 2'd0 && !fi)) begin tag = "R4"; return 0; end
    if (p == 2'd3) begin tag = "R9"; return 0; end
    if (!mw[pos]) begin tag = "R5"; return 1; end
    if (t == 2'd2) begin tag = "R10"; return 0; end
    if (vm && !hw[pos]) begin tag = "R6"; return 2; end
    if (t == 2'd0 && sm && p == 2'd0 && !sw[1]) begin
      tag = "R7"; return vm ? 2 : 1;
    end
    tag = "R8";
    return 0;
  endfunction

  task automatic check(input int exp, input string tag);
    int act;
    act = out_code();
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: verdict code %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] p, input logic vm,
      input logic st, input logic fi, input logic sm, input logic [1:0] t,
      input logic [W-1:0] mw, input logic [W-1:0] hw, input logic [W-1:0] sw,
      input logic bf, input logic bv);
    acc_valid = v; priv = p; virt_mode = vm; ext_stateen = st;
    ext_fp_in_int = fi; ext_smode = sm; tgt = t; m_word = mw; h_word = hw;
    s_word = sw; base_fault = bf; base_virt = bv;
  endtask

  typedef struct packed {
    logic [1:0]   p;
    logic         vm, st, fi, sm;
    logic [1:0]   t;
    logic [W-1:0] mw, hw, sw;
    logic         bf, bv;
    logic [1:0]   exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t TBL [NVEC] = '{
    '{2'd0,1'b0,1'b1,1'b1,1'b1,2'd0,NO62,ONES,ONES,1'b0,1'b0,2'd0,4'd5},  // R5 bit 62 ignored for fp
    '{2'd1,1'b0,1'b1,1'b0,1'b1,2'd1,NO1 ,ONES,ONES,1'b0,1'b0,2'd0,4'd5},  // R5 bit 1 ignored for env
    '{2'd1,1'b0,1'b1,1'b0,1'b1,2'd1,NO62,ONES,ONES,1'b0,1'b0,2'd1,4'd5},
    '{2'd1,1'b1,1'b1,1'b0,1'b1,2'd1,ONES,NO62,ONES,1'b0,1'b0,2'd2,4'd6},  // R6
    '{2'd1,1'b1,1'b1,1'b0,1'b1,2'd2,ONES,ZERO,ZERO,1'b0,1'b0,2'd0,4'd10}, // R10
    '{2'd0,1'b1,1'b1,1'b1,1'b1,2'd0,ONES,ONES,ZERO,1'b0,1'b0,2'd2,4'd7},  // R7 virtual
    '{2'd0,1'b0,1'b1,1'b1,1'b0,2'd0,ONES,ONES,ZERO,1'b0,1'b0,2'd0,4'd7},  // R7 no S mode
    '{2'd3,1'b1,1'b1,1'b1,1'b1,2'd0,ZERO,ZERO,ZERO,1'b0,1'b0,2'd0,4'd9},  // R9
    '{2'd0,1'b1,1'b1,1'b1,1'b1,2'd0,ZERO,ZERO,ZERO,1'b0,1'b0,2'd1,4'd8},  // R8 machine first
    '{2'd1,1'b1,1'b1,1'b1,1'b1,2'd0,ONES,ZERO,ZERO,1'b0,1'b0,2'd2,4'd8},  // R8 hyp before sup
    '{2'd0,1'b0,1'b1,1'b0,1'b1,2'd0,ZERO,ZERO,ZERO,1'b0,1'b0,2'd0,4'd4},  // R4
    '{2'd0,1'b0,1'b0,1'b1,1'b1,2'd1,ZERO,ZERO,ZERO,1'b0,1'b0,2'd0,4'd3},  // R3
    '{2'd1,1'b0,1'b1,1'b1,1'b1,2'd3,ZERO,ZERO,ZERO,1'b0,1'b0,2'd0,4'd4},  // R4 unguarded
    '{2'd0,1'b0,1'b1,1'b1,1'b1,2'd0,ZERO,ZERO,ZERO,1'b1,1'b1,2'd2,4'd2},  // R2
    '{2'd2,1'b0,1'b1,1'b1,1'b1,2'd0,ONES,ONES,ZERO,1'b0,1'b0,2'd0,4'd7}   // R7 reserved priv
  };

  initial begin
    #500000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, got hang, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    string tag;
    int exp;
    rst_n = 1'b0;
    drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, ZERO, ZERO, ZERO, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(3, "R11 reset");
    rst_n = 1'b1;
    drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, ONES, ONES, ONES, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check(3, "R1 idle");

    // R11 latency: verdict not visible before the edge
    drive(1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, ZERO, ONES, ONES, 1'b0, 1'b0);
    #1;
    check(3, "R11 before edge");
    @(posedge clk); @(negedge clk);
    check(1, "R11 after edge");

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      drive(1'b1, TBL[k].p, TBL[k].vm, TBL[k].st, TBL[k].fi, TBL[k].sm,
            TBL[k].t, TBL[k].mw, TBL[k].hw, TBL[k].sw, TBL[k].bf, TBL[k].bv);
      @(posedge clk); @(negedge clk);
      check(int'(TBL[k].exp), $sformatf("R%0d table %0d", TBL[k].req, k));
    end

    // exhaustive sweep against the reference model
    for (int idx = 0; idx < 8192; idx++) begin
      logic [1:0] p, t;
      logic vm, st, fi, sm, mb, hb, sb, bf, bv;
      p  = idx[1:0];
      vm = idx[2];  st = idx[3];  fi = idx[4];  sm = idx[5];
      t  = idx[7:6];
      mb = idx[8];  hb = idx[9];  sb = idx[10];
      bf = idx[11]; bv = idx[12];
      drive(1'b1, p, vm, st, fi, sm, t, mb ? ONES : NOBOTH,
            hb ? ONES : NOBOTH, sb ? ONES : NOBOTH, bf, bv);
      exp = ref_code(1'b1, p, vm, st, fi, sm, t, mb ? ONES : NOBOTH,
                     hb ? ONES : NOBOTH, sb ? ONES : NOBOTH, bf, bv, tag);
      @(posedge clk); @(negedge clk);
      check(exp, $sformatf("%s sweep %0d", tag, idx));
    end

    // back to idle, then reset in the middle of a verdict
    drive(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, ZERO, ZERO, ZERO, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check(3, "R1 idle with fault");
    drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, ZERO, ZERO, ZERO, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    check(1, "R5 before reset");
    rst_n = 1'b0;
    #1;
    check(3, "R11 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule